// File: doc/BRIEF.md
# Host Command and Status Mailbox

This block is a byte-wide mailbox between a host bus and a local controller. Bytes written by the host are queued in a command FIFO until the controller reads them. Bytes written by the controller are queued in a status FIFO until the host reads them. An active-low status-ready line tells the host when it may collect status. An active-low data-ready line tells the host when the data path may move bytes.

The controller governs the mailbox through one 8-bit control register. The register holds two output enables, two wait interlocks, a command-break disable and three interrupt masks. The wait interlocks cross-couple the two transfer kinds:
- With the status interlock on, status is not offered while a data transfer is busy.
- With the data interlock on, data is not offered while status is pending.

When command break is enabled, any host command write aborts the transfers that are in flight. The block also keeps three flags: command pending, data-transfer end and decode. It combines each flag with its mask to drive an active-low interrupt to the controller.

All requests are single-cycle strobes in one clock domain. All outputs come from registered state, so the effect of a strobe is visible after the next rising clock edge.

Top module: `cmd_status_mailbox`

## Requirements
- R1: The command FIFO holds up to DEPTH (default 12) bytes and returns them to the controller in the order the host wrote them. A host write while DEPTH bytes are queued is dropped and leaves the queued bytes intact.
- R2: cmdPending is high exactly while at least one command byte is queued. When the command FIFO is empty, cpuCmdData reads 0xFF, and a controller read changes nothing.
- R3: The status FIFO holds up to DEPTH bytes in order. A controller write while it is full is ignored. When it is empty, hostStsData reads 0xFF.
- R4: An accepted controller status write sets stsBusy. stsBusy clears on the edge at which the host takes the last queued status byte.
- R5: While control bit 0 (status output enable) is 0, the status FIFO is flushed, status writes are ignored and stsBusy is 0. While control bit 1 (data output enable) is 0, dataBusy is 0 and dataStart is ignored. dataStart sets dataBusy, and dataDone clears it.
- R6: When control bit 2 is 0 (status wait on), stenN is low only while stsBusy is 1 and dataBusy is 0. When bit 2 is 1, stenN is low whenever stsBusy is 1.
- R7: When control bit 3 is 0 (data wait on), dtenN is low only while dataBusy is 1 and stsBusy is 0. When bit 3 is 1, dtenN is low whenever dataBusy is 1.
- R8: When control bit 4 is 0 (break on), a host command write clears dataBusy and stsBusy and flushes the status FIFO, and it does not set dteFlag. When bit 4 is 1, a host command write does none of this.
- R9: dteFlag is set by dataDone while dataBusy is 1 and the transfer is not being aborted, and is cleared by dataEndAck. decFlag is set by decodeEvt and cleared by decodeAck. A set and a clear in the same cycle leave the flag set.
- R10: cpuIntN is low exactly when any of three pairs is active: (cmdPending and control bit 5), (dteFlag and bit 6), (decFlag and bit 7). The mask bits never change the flags.
- R11: After reset the control register is 0, both FIFOs are empty, all flags and busy bits are 0, stenN, dtenN and cpuIntN are high, and both read ports show 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostCmdWr | input | 1 | Host command byte write strobe |
| hostCmdData | input | WIDTH | Host command byte |
| hostStsRd | input | 1 | Host status byte read strobe |
| hostStsData | output | WIDTH | Head of status FIFO, 0xFF when empty |
| stenN | output | 1 | Status ready to host, active low |
| dtenN | output | 1 | Data ready to host, active low |
| cpuCmdRd | input | 1 | Controller command read strobe |
| cpuCmdData | output | WIDTH | Head of command FIFO, 0xFF when empty |
| cpuStsWr | input | 1 | Controller status byte write strobe |
| cpuStsData | input | WIDTH | Controller status byte |
| ctrlWr | input | 1 | Control register write strobe |
| ctrlData | input | 8 | Control register value |
| dataStart | input | 1 | Controller starts a data transfer |
| dataDone | input | 1 | Data transfer reached its end |
| dataEndAck | input | 1 | Controller clears the data-end flag |
| decodeEvt | input | 1 | New decoded sector event |
| decodeAck | input | 1 | Controller clears the decode flag |
| cmdPending | output | 1 | Command bytes are queued |
| stsBusy | output | 1 | Status transfer busy |
| dataBusy | output | 1 | Data transfer busy |
| dteFlag | output | 1 | Data transfer end flag |
| decFlag | output | 1 | Decode flag |
| cpuIntN | output | 1 | Masked interrupt to controller, active low |

## Verification
The bench builds the block with its default parameters: DEPTH of 12 and WIDTH of 8. At this size a few directed bursts reach both the full and the empty boundary of each FIFO, and the random phase keeps crossing them. Random control writes reach every combination of the two wait bits, the break bit and the masks. The random phase also produces coincidences that the directed cases do not list, such as a command break in the same cycle as dataDone, or a status write into a full queue while the host is reading.

// File: rtl/mailbox_pkg.sv
package mailbox_pkg;

  // Control register layout, bit 7 down to bit 0.
  typedef struct packed {
    logic decIntEn;     // 7
    logic dteIntEn;     // 6
    logic cmdIntEn;     // 5
    logic breakOff;     // 4: 1 disables command break
    logic dataWaitOff;  // 3: 1 disables data wait
    logic stsWaitOff;   // 2: 1 disables status wait
    logic dataOutEn;    // 1
    logic stsOutEn;     // 0
  } ctrl_t;

  typedef struct packed {
    logic cmdPush;
    logic cmdPop;
    logic stsPush;
    logic stsPop;
    logic stsFlush;
  } strobe_t;

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DEPTH = 12,
  parameter int WIDTH = 8,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [LW-1:0]    level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wPtr, rPtr;
  logic             isEmpty, isFull, doPush, doPop;

  assign isEmpty = (level == '0);
  assign isFull  = (level == LW'(DEPTH));
  assign doPush  = push && !isFull && !flush;
  assign doPop   = pop && !isEmpty && !flush;
  assign rdData  = isEmpty ? '1 : mem[rPtr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wPtr  <= '0;
      rPtr  <= '0;
      level <= '0;
    end else if (flush) begin
      wPtr  <= '0;
      rPtr  <= '0;
      level <= '0;
    end else begin
      if (doPush) wPtr <= bump(wPtr);
      if (doPop)  rPtr <= bump(rPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath import mailbox_pkg::*; #(
  parameter int DEPTH = 12,
  parameter int WIDTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] hostCmdData,
  input  logic [WIDTH-1:0] cpuStsData,
  output logic [WIDTH-1:0] cpuCmdData,
  output logic [WIDTH-1:0] hostStsData,
  output logic [LW-1:0]    cmdLevel,
  output logic [LW-1:0]    stsLevel
);

  mbx_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) cmdFifo (
    .clk(clk), .rstN(rstN),
    .push(stb.cmdPush), .pop(stb.cmdPop), .flush(1'b0),
    .wrData(hostCmdData), .rdData(cpuCmdData), .level(cmdLevel)
  );

  mbx_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) stsFifo (
    .clk(clk), .rstN(rstN),
    .push(stb.stsPush), .pop(stb.stsPop), .flush(stb.stsFlush),
    .wrData(cpuStsData), .rdData(hostStsData), .level(stsLevel)
  );

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl import mailbox_pkg::*; #(
  parameter int DEPTH = 12,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostCmdWr,
  input  logic          hostStsRd,
  input  logic          cpuCmdRd,
  input  logic          cpuStsWr,
  input  logic          ctrlWr,
  input  logic [7:0]    ctrlData,
  input  logic          dataStart,
  input  logic          dataDone,
  input  logic          dataEndAck,
  input  logic          decodeEvt,
  input  logic          decodeAck,
  input  logic [LW-1:0] cmdLevel,
  input  logic [LW-1:0] stsLevel,
  output strobe_t       stb,
  output ctrl_t         ctrlQ,
  output logic          cmdPending,
  output logic          stsBusy,
  output logic          dataBusy,
  output logic          dteFlag,
  output logic          decFlag,
  output logic          stenN,
  output logic          dtenN,
  output logic          cpuIntN
);

  logic cmdEmpty, cmdFull, stsEmpty, stsFull, stsLast;
  logic breakHit, stsAbort, dataAbort;

  assign cmdEmpty = (cmdLevel == '0);
  assign cmdFull  = (cmdLevel == LW'(DEPTH));
  assign stsEmpty = (stsLevel == '0);
  assign stsFull  = (stsLevel == LW'(DEPTH));
  assign stsLast  = (stsLevel == LW'(1));

  assign breakHit  = hostCmdWr && !ctrlQ.breakOff;
  assign stsAbort  = !ctrlQ.stsOutEn || breakHit;
  assign dataAbort = !ctrlQ.dataOutEn || breakHit;

  always_comb begin
    stb.cmdPush  = hostCmdWr && !cmdFull;
    stb.cmdPop   = cpuCmdRd && !cmdEmpty;
    stb.stsFlush = stsAbort;
    stb.stsPush  = cpuStsWr && !stsFull && !stsAbort;
    stb.stsPop   = hostStsRd && !stsEmpty && !stsAbort;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      stsBusy  <= 1'b0;
      dataBusy <= 1'b0;
      dteFlag  <= 1'b0;
      decFlag  <= 1'b0;
    end else begin
      if (ctrlWr) ctrlQ <= ctrl_t'(ctrlData);

      if (stsAbort)                    stsBusy <= 1'b0;
      else if (cpuStsWr)               stsBusy <= 1'b1;
      else if (stb.stsPop && stsLast)  stsBusy <= 1'b0;

      if (dataAbort)      dataBusy <= 1'b0;
      else if (dataStart) dataBusy <= 1'b1;
      else if (dataDone)  dataBusy <= 1'b0;

      if (dataDone && dataBusy && !dataAbort) dteFlag <= 1'b1;
      else if (dataEndAck)                    dteFlag <= 1'b0;

      if (decodeEvt)      decFlag <= 1'b1;
      else if (decodeAck) decFlag <= 1'b0;
    end
  end

  assign cmdPending = !cmdEmpty;
  assign stenN = !(stsBusy && (ctrlQ.stsWaitOff || !dataBusy));
  assign dtenN = !(dataBusy && (ctrlQ.dataWaitOff || !stsBusy));
  assign cpuIntN = !(|({ctrlQ.decIntEn, ctrlQ.dteIntEn, ctrlQ.cmdIntEn}
                       & {decFlag, dteFlag, cmdPending}));

endmodule

// File: rtl/cmd_status_mailbox.sv
module cmd_status_mailbox import mailbox_pkg::*; #(
  parameter int DEPTH = 12,
  parameter int WIDTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostCmdWr,
  input  logic [WIDTH-1:0] hostCmdData,
  input  logic             hostStsRd,
  output logic [WIDTH-1:0] hostStsData,
  output logic             stenN,
  output logic             dtenN,
  input  logic             cpuCmdRd,
  output logic [WIDTH-1:0] cpuCmdData,
  input  logic             cpuStsWr,
  input  logic [WIDTH-1:0] cpuStsData,
  input  logic             ctrlWr,
  input  logic [7:0]       ctrlData,
  input  logic             dataStart,
  input  logic             dataDone,
  input  logic             dataEndAck,
  input  logic             decodeEvt,
  input  logic             decodeAck,
  output logic             cmdPending,
  output logic             stsBusy,
  output logic             dataBusy,
  output logic             dteFlag,
  output logic             decFlag,
  output logic             cpuIntN
);

  strobe_t       stb;
  ctrl_t         ctrlQ;
  logic [LW-1:0] cmdLevel, stsLevel;

  mbx_ctrl #(.DEPTH(DEPTH)) ctrlUnit (
    .clk(clk), .rstN(rstN),
    .hostCmdWr(hostCmdWr), .hostStsRd(hostStsRd),
    .cpuCmdRd(cpuCmdRd), .cpuStsWr(cpuStsWr),
    .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .dataStart(dataStart), .dataDone(dataDone), .dataEndAck(dataEndAck),
    .decodeEvt(decodeEvt), .decodeAck(decodeAck),
    .cmdLevel(cmdLevel), .stsLevel(stsLevel),
    .stb(stb), .ctrlQ(ctrlQ),
    .cmdPending(cmdPending), .stsBusy(stsBusy), .dataBusy(dataBusy),
    .dteFlag(dteFlag), .decFlag(decFlag),
    .stenN(stenN), .dtenN(dtenN), .cpuIntN(cpuIntN)
  );

  mbx_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dataUnit (
    .clk(clk), .rstN(rstN), .stb(stb),
    .hostCmdData(hostCmdData), .cpuStsData(cpuStsData),
    .cpuCmdData(cpuCmdData), .hostStsData(hostStsData),
    .cmdLevel(cmdLevel), .stsLevel(stsLevel)
  );

endmodule

// File: rtl/mailbox_checker.sv
module mailbox_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostCmdWr,
  input logic [7:0]       ctrlQ,
  input logic [WIDTH-1:0] cpuCmdData,
  input logic             cmdPending,
  input logic             stsBusy,
  input logic             dataBusy,
  input logic             dteFlag,
  input logic             stenN,
  input logic             dtenN,
  input logic             cpuIntN
);

  // R2
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdPending |-> (cpuCmdData == {WIDTH{1'b1}}));

  // R5
  sts_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[0] |=> !stsBusy);

  // R5
  data_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[1] |=> !dataBusy);

  // R6
  sts_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stenN && !ctrlQ[2]) |-> (stsBusy && !dataBusy));

  // R7
  data_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dtenN && !ctrlQ[3]) |-> (dataBusy && !stsBusy));

  // R8
  break_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostCmdWr && !ctrlQ[4]) |=> (!dataBusy && !stsBusy));

  // R8
  break_no_dte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostCmdWr && !ctrlQ[4] && !dteFlag) |=> !dteFlag);

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[7:5] == 3'b000) |-> cpuIntN);

endmodule

bind cmd_status_mailbox mailbox_checker #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rstN(rstN), .hostCmdWr(hostCmdWr), .ctrlQ(ctrlQ),
  .cpuCmdData(cpuCmdData), .cmdPending(cmdPending), .stsBusy(stsBusy),
  .dataBusy(dataBusy), .dteFlag(dteFlag), .stenN(stenN), .dtenN(dtenN),
  .cpuIntN(cpuIntN)
);

// File: tb/cmd_status_mailbox_tb_top.sv
`timescale 1ns/1ps
module cmd_status_mailbox_tb_top;

  localparam int DEPTH = 12;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN;
  logic hostCmdWr, hostStsRd, cpuCmdRd, cpuStsWr, ctrlWr;
  logic [7:0] hostCmdData, cpuStsData, ctrlData;
  logic dataStart, dataDone, dataEndAck, decodeEvt, decodeAck;
  logic [7:0] hostStsData, cpuCmdData;
  logic stenN, dtenN, cmdPending, stsBusy, dataBusy, dteFlag, decFlag, cpuIntN;

  cmd_status_mailbox #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rstN(rstN),
    .hostCmdWr(hostCmdWr), .hostCmdData(hostCmdData),
    .hostStsRd(hostStsRd), .hostStsData(hostStsData),
    .stenN(stenN), .dtenN(dtenN),
    .cpuCmdRd(cpuCmdRd), .cpuCmdData(cpuCmdData),
    .cpuStsWr(cpuStsWr), .cpuStsData(cpuStsData),
    .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .dataStart(dataStart), .dataDone(dataDone), .dataEndAck(dataEndAck),
    .decodeEvt(decodeEvt), .decodeAck(decodeAck),
    .cmdPending(cmdPending), .stsBusy(stsBusy), .dataBusy(dataBusy),
    .dteFlag(dteFlag), .decFlag(decFlag), .cpuIntN(cpuIntN)
  );

  int total = 0;
  int bad = 0;

  // Reference model state
  logic [7:0] mCmdQ[$];
  logic [7:0] mStsQ[$];
  logic [7:0] mCtrl;
  logic mStsBusy, mDataBusy, mDte, mDec;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expStenN();
    return (mStsBusy && (mCtrl[2] || !mDataBusy)) ? 0 : 1;
  endfunction

  function automatic int expDtenN();
    return (mDataBusy && (mCtrl[3] || !mStsBusy)) ? 0 : 1;
  endfunction

  function automatic int expIntN();
    logic any;
    any = (mCtrl[5] && mCmdQ.size() > 0) || (mCtrl[6] && mDte) || (mCtrl[7] && mDec);
    return any ? 0 : 1;
  endfunction

  task automatic compare();
    chk("R1 cpuCmdData", cpuCmdData, (mCmdQ.size() > 0) ? mCmdQ[0] : 8'hFF);
    chk("R2 cmdPending", cmdPending, (mCmdQ.size() > 0) ? 1 : 0);
    chk("R3 hostStsData", hostStsData, (mStsQ.size() > 0) ? mStsQ[0] : 8'hFF);
    chk("R4 stsBusy", stsBusy, mStsBusy);
    chk("R5 dataBusy", dataBusy, mDataBusy);
    chk("R6 stenN", stenN, expStenN());
    chk("R7 dtenN", dtenN, expDtenN());
    chk("R9 dteFlag", dteFlag, mDte);
    chk("R9 decFlag", decFlag, mDec);
    chk("R10 cpuIntN", cpuIntN, expIntN());
  endtask

  task automatic clearInputs();
    hostCmdWr = 0; hostStsRd = 0; cpuCmdRd = 0; cpuStsWr = 0; ctrlWr = 0;
    dataStart = 0; dataDone = 0; dataEndAck = 0; decodeEvt = 0; decodeAck = 0;
  endtask

  // Inputs are set; advance model and design by one edge, then compare.
  task automatic step();
    logic brk, stsAb, dataAb, cmdFullNow, stsFullNow;
    int stsSize;
    brk    = hostCmdWr && !mCtrl[4];
    stsAb  = !mCtrl[0] || brk;
    dataAb = !mCtrl[1] || brk;
    cmdFullNow = (mCmdQ.size() == DEPTH);
    stsFullNow = (mStsQ.size() == DEPTH);
    stsSize = mStsQ.size();
    @(posedge clk);
    // command FIFO (R1, R2)
    if (cpuCmdRd && mCmdQ.size() > 0) void'(mCmdQ.pop_front());
    if (hostCmdWr && !cmdFullNow) mCmdQ.push_back(hostCmdData);
    // status FIFO and busy (R3, R4, R5, R8)
    if (stsAb) begin
      mStsQ.delete();
      mStsBusy = 0;
    end else begin
      if (hostStsRd && stsSize > 0) void'(mStsQ.pop_front());
      if (cpuStsWr && !stsFullNow) mStsQ.push_back(cpuStsData);
      if (cpuStsWr) mStsBusy = 1;
      else if (hostStsRd && stsSize == 1) mStsBusy = 0;
    end
    // data busy and flags (R5, R8, R9)
    if (dataDone && mDataBusy && !dataAb) mDte = 1;
    else if (dataEndAck) mDte = 0;
    if (dataAb) mDataBusy = 0;
    else if (dataStart) mDataBusy = 1;
    else if (dataDone) mDataBusy = 0;
    if (decodeEvt) mDec = 1;
    else if (decodeAck) mDec = 0;
    if (ctrlWr) mCtrl = ctrlData;
    @(negedge clk);
    clearInputs();
    compare();
  endtask

  task automatic setCtrl(input logic [7:0] v);
    ctrlWr = 1; ctrlData = v; step();
  endtask

  initial begin : watchdog
    #(150000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    clearInputs();
    hostCmdData = 0; cpuStsData = 0; ctrlData = 0;
    mCtrl = 0; mStsBusy = 0; mDataBusy = 0; mDte = 0; mDec = 0;
    rstN = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 cpuCmdData", cpuCmdData, 8'hFF);
    chk("R11 hostStsData", hostStsData, 8'hFF);
    chk("R11 stenN", stenN, 1);
    chk("R11 dtenN", dtenN, 1);
    chk("R11 cpuIntN", cpuIntN, 1);
    chk("R11 flags", {cmdPending, stsBusy, dataBusy, dteFlag, decFlag}, 0);
    rstN = 1;
    @(negedge clk);
    compare();

    // R1 and R2: overfill the command FIFO with break off, drain past empty
    setCtrl(8'h13);
    for (int i = 0; i < DEPTH + 2; i++) begin
      hostCmdWr = 1; hostCmdData = 8'h40 + 8'(i); step();
    end
    chk("R1 full level held", cmdPending, 1);
    for (int i = 0; i < DEPTH + 2; i++) begin
      cpuCmdRd = 1; step();
    end
    chk("R2 empty read", cpuCmdData, 8'hFF);

    // R3 and R4: overfill the status FIFO without wait, drain it
    setCtrl(8'h17);
    for (int i = 0; i < DEPTH + 2; i++) begin
      cpuStsWr = 1; cpuStsData = 8'h90 + 8'(i); step();
    end
    for (int i = 0; i < DEPTH + 1; i++) begin
      hostStsRd = 1; step();
    end
    chk("R4 busy clear after drain", stsBusy, 0);

    // R6: status wait holds stenN high during a data transfer
    setCtrl(8'h13);
    dataStart = 1; step();
    cpuStsWr = 1; cpuStsData = 8'h5A; step();
    chk("R6 stenN held", stenN, 1);
    chk("R7 dtenN blocked by status", dtenN, 1);
    dataDone = 1; step();
    chk("R6 stenN after data end", stenN, 0);
    dataEndAck = 1; hostStsRd = 1; step();

    // R8: command break aborts both transfers without setting dteFlag
    setCtrl(8'h03);
    dataStart = 1; step();
    cpuStsWr = 1; cpuStsData = 8'hA5; step();
    hostCmdWr = 1; hostCmdData = 8'h77; dataDone = 1; step();
    chk("R8 dataBusy cleared", dataBusy, 0);
    chk("R8 stsBusy cleared", stsBusy, 0);
    chk("R8 no dteFlag", dteFlag, 0);
    chk("R8 status flushed", hostStsData, 8'hFF);
    cpuCmdRd = 1; step();

    // R9 and R10: flags and masks
    setCtrl(8'hE3);
    decodeEvt = 1; step();
    chk("R10 int from decode", cpuIntN, 0);
    setCtrl(8'h63);
    chk("R10 mask leaves flag", decFlag, 1);
    decodeEvt = 1; decodeAck = 1; step();
    chk("R9 set wins", decFlag, 1);
    decodeAck = 1; step();

    // R5: disabling outputs flushes and aborts
    setCtrl(8'h17);
    cpuStsWr = 1; cpuStsData = 8'h11; dataStart = 1; step();
    setCtrl(8'h00);
    step();
    chk("R5 status flushed", hostStsData, 8'hFF);
    chk("R5 data aborted", dataBusy, 0);
    dataStart = 1; cpuStsWr = 1; step();
    chk("R5 start ignored", dataBusy, 0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      hostCmdWr   = ($urandom_range(0, 99) < 25);
      hostCmdData = 8'($urandom);
      cpuCmdRd    = ($urandom_range(0, 99) < 25);
      cpuStsWr    = ($urandom_range(0, 99) < 25);
      cpuStsData  = 8'($urandom);
      hostStsRd   = ($urandom_range(0, 99) < 25);
      dataStart   = ($urandom_range(0, 99) < 10);
      dataDone    = ($urandom_range(0, 99) < 10);
      dataEndAck  = ($urandom_range(0, 99) < 8);
      decodeEvt   = ($urandom_range(0, 99) < 8);
      decodeAck   = ($urandom_range(0, 99) < 8);
      if (r < 3) begin
        ctrlWr = 1;
        ctrlData = 8'($urandom);
        if ($urandom_range(0, 7) != 0) ctrlData[0] = 1'b1;
        if ($urandom_range(0, 7) != 0) ctrlData[1] = 1'b1;
        if ($urandom_range(0, 3) != 0) ctrlData[4] = 1'b1;
      end
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule